// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Command Sequencer

This block drives the command stream a DDR3-style memory controller needs outside normal traffic. It covers two flows: bringing the memory out of power-up, and refreshing it at a steady rate. Both flows are fixed programs stored in a small table. Each table entry gives a command, the level of the memory's active-low reset pin, whether a delay counter runs, the delay length, and whether the entry ends its program. The sequencer steps through the entries in order.

The main read/write engine starts the power-up flow with a one-cycle pulse. Once initialisation has finished, a free-running interval counter raises a refresh request every `REFRESH_INTERVAL` cycles. The engine accepts the request by granting the bus. A refresh does not track open banks. It always spends a write-drain window first, which lasts longer while a write is still in flight. It then issues an unconditional precharge-all followed by a refresh. While either flow runs, a busy flag blocks normal traffic. A one-cycle done pulse marks the end of each flow.

Top module: `dram_cmd_sequencer`

## Requirements
- R1: After reset, `cmdCode` is 0 (NOOP), `dramResetN` is 0, and `seqBusy`, `seqDone` and `refreshDue` are 0.
- R2: Command codes are NOOP=0, PRECHARGE_ALL=1, REFRESH=2, MODE_SET=3, CALIBRATE=4. The power-up program has eight entries. The first is a NOOP lasting RESET_HOLD (8000) cycles. The second is a NOOP lasting POST_RESET (100) cycles. The third is a one-cycle NOOP with its timer off. Then come four MODE_SET entries lasting 4, 4, 4 and 12 cycles. The last is a CALIBRATE entry lasting 512 cycles.
- R3: `dramResetN` is 0 for every cycle of the first power-up entry, is 1 from the second entry onward, and stays 1 while idle and during refreshes afterwards.
- R4: An entry whose timer is on, with length N, drives its command in its first cycle and NOOP in its other N-1 cycles. An entry whose timer is off lasts exactly one cycle.
- R5: `seqBusy` is 1 from the cycle after a program starts through that program's last cycle. `seqDone` is 1 only in the following cycle, and `seqBusy` is 0 in that cycle.
- R6: `refreshDue` is 0 until REFRESH_INTERVAL (1560) cycles after the power-up done cycle, and rises in exactly that cycle. It then stays 1 until a refresh is accepted.
- R7: No refresh starts before power-up has completed, even with `busGrant` high. No refresh starts while `busGrant` is low.
- R8: An accepted refresh first spends at least DRAIN_CYCLES (6) NOOP cycles, even with `writeBusy` low. The window ends DRAIN_CYCLES cycles after the last cycle in which `writeBusy` was high.
- R9: After the drain, PRECHARGE_ALL is issued for a 3-cycle entry, then REFRESH for a 32-cycle entry, and then the done pulse follows.
- R10: An `initStart` pulse that arrives while `seqBusy` is 1 has no effect on the running program.
- R11: When a refresh is accepted on the same clock edge on which the interval counter expires, `refreshDue` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initStart | input | 1 | One-cycle pulse that starts the power-up program when idle |
| busGrant | input | 1 | Main engine yields the bus so a pending refresh may start |
| writeBusy | input | 1 | A write is still in flight in the main engine |
| cmdCode | output | 3 | Command to the memory (0 NOOP, 1 PRECHARGE_ALL, 2 REFRESH, 3 MODE_SET, 4 CALIBRATE) |
| dramResetN | output | 1 | Level for the memory's active-low reset pin |
| seqBusy | output | 1 | A program or drain is running; normal traffic must wait |
| seqDone | output | 1 | One-cycle pulse after a program's last entry |
| refreshDue | output | 1 | A refresh interval has elapsed and no refresh has yet been accepted |

## Verification
The interval counter's expiry and the acceptance of a refresh that is already pending can fall on the same clock edge. In that case the set of the pending flag and its clear compete. The bench provokes this by holding `busGrant` low through one whole interval after the first request. It then raises the grant for the single cycle whose closing edge is the second expiry. The coincidence is judged correct if `seqBusy` rises and `refreshDue` is still 1 in the next cycle, and if a second refresh can then start without waiting another interval.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOOP    = 3'd0,
    CMD_PREALL  = 3'd1,
    CMD_REFRESH = 3'd2,
    CMD_MODESET = 3'd3,
    CMD_CALIB   = 3'd4
  } cmd_e;

  localparam int TIMER_W = 16;

  typedef struct packed {
    cmd_e               cmd;
    logic [TIMER_W-1:0] count;
    logic               timerEn;
    logic               resetLevel;
    logic               lastEntry;
  } entry_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic running;
    logic draining;
    logic loadInit;
    logic acceptRefresh;
    logic loadRefresh;
    logic advance;
    logic finishInit;
  } strobe_t;

endpackage

// File: rtl/dram_seq_dp.sv
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int RESET_HOLD       = 8000,
  parameter int POST_RESET       = 100,
  parameter int T_MRD            = 4,
  parameter int T_MOD            = 12,
  parameter int T_ZQINIT         = 512,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 32,
  parameter int DRAIN_CYCLES     = 6,
  parameter int REFRESH_INTERVAL = 1560
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t st,
  input  logic    writeBusy,
  output cmd_e    cmdOut,
  output logic    dramResetN,
  output logic    entryExpired,
  output logic    entryLast,
  output logic    drainZero,
  output logic    initDone,
  output logic    refreshDue
);

  localparam int ENTRY_COUNT = 10;
  localparam int PTR_W       = $clog2(ENTRY_COUNT);
  localparam logic [PTR_W-1:0] REF_START = PTR_W'(8);
  localparam int DRAIN_W     = $clog2(DRAIN_CYCLES + 1);
  localparam int INTERVAL_W  = $clog2(REFRESH_INTERVAL);

  function automatic entry_t mk(input cmd_e c, input int n, input logic en,
                                input logic lvl, input logic last);
    entry_t e;
    e.cmd        = c;
    e.count      = TIMER_W'(n);
    e.timerEn    = en;
    e.resetLevel = lvl;
    e.lastEntry  = last;
    return e;
  endfunction

  // 0..7 power-up program, 8..9 refresh program
  function automatic entry_t entryAt(input logic [PTR_W-1:0] idx);
    case (idx)
      4'd0:    return mk(CMD_NOOP,    RESET_HOLD, 1'b1, 1'b0, 1'b0);
      4'd1:    return mk(CMD_NOOP,    POST_RESET, 1'b1, 1'b1, 1'b0);
      4'd2:    return mk(CMD_NOOP,    1,          1'b0, 1'b1, 1'b0);
      4'd3:    return mk(CMD_MODESET, T_MRD,      1'b1, 1'b1, 1'b0);
      4'd4:    return mk(CMD_MODESET, T_MRD,      1'b1, 1'b1, 1'b0);
      4'd5:    return mk(CMD_MODESET, T_MRD,      1'b1, 1'b1, 1'b0);
      4'd6:    return mk(CMD_MODESET, T_MOD,      1'b1, 1'b1, 1'b0);
      4'd7:    return mk(CMD_CALIB,   T_ZQINIT,   1'b1, 1'b1, 1'b1);
      4'd8:    return mk(CMD_PREALL,  T_RP,       1'b1, 1'b1, 1'b0);
      default: return mk(CMD_REFRESH, T_RFC,      1'b1, 1'b1, 1'b1);
    endcase
  endfunction

  logic [PTR_W-1:0]      ptr;
  logic [TIMER_W-1:0]    timer;
  logic                  firstCycle;
  logic                  heldLevel;
  logic [DRAIN_W-1:0]    drainCnt;
  logic [INTERVAL_W-1:0] intervalCnt;
  logic                  intervalExpire;
  cmd_e                  curCmd;
  logic                  curTimerEn, curLevel;

  assign curCmd     = entryAt(ptr).cmd;
  assign curTimerEn = entryAt(ptr).timerEn;
  assign curLevel   = entryAt(ptr).resetLevel;
  assign entryLast  = entryAt(ptr).lastEntry;

  // entry pointer and delay timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      timer      <= '0;
      firstCycle <= 1'b0;
    end else if (st.loadInit) begin
      ptr        <= '0;
      timer      <= entryAt('0).count - 1'b1;
      firstCycle <= 1'b1;
    end else if (st.loadRefresh) begin
      ptr        <= REF_START;
      timer      <= entryAt(REF_START).count - 1'b1;
      firstCycle <= 1'b1;
    end else if (st.advance) begin
      ptr        <= ptr + 1'b1;
      timer      <= entryAt(ptr + 1'b1).count - 1'b1;
      firstCycle <= 1'b1;
    end else begin
      firstCycle <= 1'b0;
      if (st.running && timer != '0) timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           heldLevel <= 1'b0;
    else if (st.running) heldLevel <= curLevel;
  end

  assign entryExpired = !curTimerEn || (timer == '0);
  assign cmdOut       = (st.running && firstCycle) ? curCmd : CMD_NOOP;
  assign dramResetN   = st.running ? curLevel : heldLevel;

  // write drain window
  always_ff @(posedge clk) begin
    if (!rstN)                 drainCnt <= '0;
    else if (st.acceptRefresh) drainCnt <= DRAIN_W'(DRAIN_CYCLES - 1);
    else if (st.draining) begin
      if (writeBusy)             drainCnt <= DRAIN_W'(DRAIN_CYCLES - 1);
      else if (drainCnt != '0)   drainCnt <= drainCnt - 1'b1;
    end
  end

  assign drainZero = (drainCnt == '0) && !writeBusy;

  // refresh interval
  assign intervalExpire = initDone && (intervalCnt == INTERVAL_W'(REFRESH_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initDone    <= 1'b0;
      intervalCnt <= '0;
      refreshDue  <= 1'b0;
    end else if (st.loadInit) begin
      initDone    <= 1'b0;
      intervalCnt <= '0;
      refreshDue  <= 1'b0;
    end else begin
      if (st.finishInit) initDone <= 1'b1;
      if (initDone) intervalCnt <= intervalExpire ? '0 : intervalCnt + 1'b1;
      refreshDue <= intervalExpire || (refreshDue && !st.acceptRefresh);
    end
  end

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    initStart,
  input  logic    busGrant,
  input  logic    entryExpired,
  input  logic    entryLast,
  input  logic    drainZero,
  input  logic    initDone,
  input  logic    refreshDue,
  output strobe_t st,
  output logic    seqBusy,
  output logic    seqDone
);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_RUN} state_e;

  state_e state, nextState;
  logic   isInit;
  logic   finishing;

  always_comb begin
    st        = '0;
    nextState = state;
    finishing = 1'b0;
    case (state)
      S_IDLE: begin
        if (initStart) begin
          st.loadInit = 1'b1;
          nextState   = S_RUN;
        end else if (initDone && refreshDue && busGrant) begin
          st.acceptRefresh = 1'b1;
          nextState        = S_DRAIN;
        end
      end
      S_DRAIN: begin
        st.draining = 1'b1;
        if (drainZero) begin
          st.loadRefresh = 1'b1;
          nextState      = S_RUN;
        end
      end
      S_RUN: begin
        st.running = 1'b1;
        if (entryExpired) begin
          if (entryLast) begin
            finishing     = 1'b1;
            st.finishInit = isInit;
            nextState     = S_IDLE;
          end else begin
            st.advance = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isInit  <= 1'b0;
      seqDone <= 1'b0;
    end else begin
      state   <= nextState;
      seqDone <= finishing;
      if (st.loadInit)           isInit <= 1'b1;
      else if (st.acceptRefresh) isInit <= 1'b0;
    end
  end

  assign seqBusy = (state != S_IDLE);

endmodule

// File: rtl/dram_cmd_sequencer.sv
module dram_cmd_sequencer
  import dram_seq_pkg::*;
#(
  parameter int RESET_HOLD       = 8000,
  parameter int POST_RESET       = 100,
  parameter int T_MRD            = 4,
  parameter int T_MOD            = 12,
  parameter int T_ZQINIT         = 512,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 32,
  parameter int DRAIN_CYCLES     = 6,
  parameter int REFRESH_INTERVAL = 1560
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initStart,
  input  logic       busGrant,
  input  logic       writeBusy,
  output logic [2:0] cmdCode,
  output logic       dramResetN,
  output logic       seqBusy,
  output logic       seqDone,
  output logic       refreshDue
);

  strobe_t st;
  cmd_e    cmdOut;
  logic    entryExpired, entryLast, drainZero, initDone;

  dram_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .initStart    (initStart),
    .busGrant     (busGrant),
    .entryExpired (entryExpired),
    .entryLast    (entryLast),
    .drainZero    (drainZero),
    .initDone     (initDone),
    .refreshDue   (refreshDue),
    .st           (st),
    .seqBusy      (seqBusy),
    .seqDone      (seqDone)
  );

  dram_seq_dp #(
    .RESET_HOLD       (RESET_HOLD),
    .POST_RESET       (POST_RESET),
    .T_MRD            (T_MRD),
    .T_MOD            (T_MOD),
    .T_ZQINIT         (T_ZQINIT),
    .T_RP             (T_RP),
    .T_RFC            (T_RFC),
    .DRAIN_CYCLES     (DRAIN_CYCLES),
    .REFRESH_INTERVAL (REFRESH_INTERVAL)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .writeBusy    (writeBusy),
    .cmdOut       (cmdOut),
    .dramResetN   (dramResetN),
    .entryExpired (entryExpired),
    .entryLast    (entryLast),
    .drainZero    (drainZero),
    .initDone     (initDone),
    .refreshDue   (refreshDue)
  );

  assign cmdCode = cmdOut;

endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       initStart,
  input logic       busGrant,
  input logic       writeBusy,
  input logic [2:0] cmdCode,
  input logic       dramResetN,
  input logic       seqBusy,
  input logic       seqDone,
  input logic       refreshDue
);

  a_r2_cmd_legal: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode <= 3'd4);

  a_r3_reset_low_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !dramResetN |-> cmdCode == 3'd0);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !seqBusy);

  a_r5_fall_gives_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqBusy) |-> seqDone);

  a_r5_cmd_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode != 3'd0 |-> seqBusy);

  a_r6_due_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (refreshDue && !busGrant && !initStart) |=> refreshDue);

  a_r8_drained_first: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == 3'd1 |-> $past(!writeBusy));

endmodule

bind dram_cmd_sequencer dram_seq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .initStart  (initStart),
  .busGrant   (busGrant),
  .writeBusy  (writeBusy),
  .cmdCode    (cmdCode),
  .dramResetN (dramResetN),
  .seqBusy    (seqBusy),
  .seqDone    (seqDone),
  .refreshDue (refreshDue)
);

// File: tb/dram_cmd_sequencer_bench.sv
`timescale 1ns/1ps
module dram_cmd_sequencer_bench;

  localparam int INTERVAL = 1560;
  localparam int DRAIN    = 6;
  localparam int RP       = 3;
  localparam int RFC      = 32;

  logic       clk = 1'b0;
  logic       rstN, initStart, busGrant, writeBusy;
  logic [2:0] cmdCode;
  logic       dramResetN, seqBusy, seqDone, refreshDue;

  int total  = 0;
  int failed = 0;

  // power-up program as required
  int initCmd [8] = '{0, 0, 0, 3, 3, 3, 3, 4};
  int initLen [8] = '{8000, 100, 1, 4, 4, 4, 12, 512};
  int initRst [8] = '{0, 1, 1, 1, 1, 1, 1, 1};

  always #10 clk = ~clk;

  dram_cmd_sequencer u_dram_cmd_sequencer (
    .clk (clk), .rstN (rstN), .initStart (initStart), .busGrant (busGrant),
    .writeBusy (writeBusy), .cmdCode (cmdCode), .dramResetN (dramResetN),
    .seqBusy (seqBusy), .seqDone (seqDone), .refreshDue (refreshDue)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic testReset();
    checkEq("R1 cmdCode", cmdCode, 0);
    checkEq("R1 dramResetN", dramResetN, 0);
    checkEq("R1 seqBusy", seqBusy, 0);
    checkEq("R1 seqDone", seqDone, 0);
    checkEq("R1 refreshDue", refreshDue, 0);
    // grant held high before power-up: R7 no refresh may start
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (i % 250 == 0) begin
        checkEq("R7 busy before init", seqBusy, 0);
        checkEq("R7 no due before init", refreshDue, 0);
      end
    end
  endtask

  // ends at the negedge of the done cycle
  task automatic runInit();
    initStart = 1'b1;
    @(negedge clk);
    initStart = 1'b0;
    for (int e = 0; e < 8; e++) begin
      for (int k = 0; k < initLen[e]; k++) begin
        checkEq("R2/R4 init cmd", cmdCode, (k == 0) ? initCmd[e] : 0);
        checkEq("R3 reset level", dramResetN, initRst[e]);
        checkEq("R5 busy in init", seqBusy, 1);
        checkEq("R5 no early done", seqDone, 0);
        initStart = (e == 1 && k == 5); // R10 pulse while busy
        @(negedge clk);
      end
    end
    checkEq("R5 done pulse", seqDone, 1);
    checkEq("R5 idle at done", seqBusy, 0);
    checkEq("R3 level after init", dramResetN, 1);
  endtask

  // cycle c = 0 is the first drain cycle, at its negedge
  task automatic refreshStream(input int w);
    for (int c = 0; c <= w + DRAIN + RP + RFC; c++) begin
      int expCmd;
      expCmd = (c == w + DRAIN) ? 1 : (c == w + DRAIN + RP) ? 2 : 0;
      checkEq((c < w + DRAIN) ? "R8 drain noop" : "R9 refresh cmd", cmdCode, expCmd);
      checkEq("R9 busy", seqBusy, (c < w + DRAIN + RP + RFC) ? 1 : 0);
      checkEq("R9 done", seqDone, (c == w + DRAIN + RP + RFC) ? 1 : 0);
      checkEq("R3 level in refresh", dramResetN, 1);
      writeBusy = (c < w);
      @(negedge clk);
    end
    writeBusy = 1'b0;
  endtask

  task automatic testIntervalAndSameEdge();
    busGrant = 1'b0;
    for (int j = 1; j <= 2 * INTERVAL; j++) begin
      @(negedge clk);
      if (j == INTERVAL - 1) checkEq("R6 due not yet", refreshDue, 0);
      if (j == INTERVAL)     checkEq("R6 due rises", refreshDue, 1);
      if (j == INTERVAL + 1) checkEq("R6 due holds", refreshDue, 1);
      if (j == 2 * INTERVAL - 1) begin
        checkEq("R7 no start without grant", seqBusy, 0);
        checkEq("R6 due still pending", refreshDue, 1);
        busGrant = 1'b1; // accept edge coincides with second expiry
      end
      if (j == 2 * INTERVAL) begin
        checkEq("R11 refresh started", seqBusy, 1);
        checkEq("R11 due re-armed", refreshDue, 1);
        busGrant = 1'b0;
      end
    end
    refreshStream(0);
  endtask

  task automatic testWriteDrain();
    checkEq("R11 due still set", refreshDue, 1);
    busGrant  = 1'b1;
    writeBusy = 1'b1;
    @(negedge clk);
    busGrant = 1'b0;
    checkEq("R8 drain starts", seqBusy, 1);
    refreshStream(10);
  endtask

  initial begin
    rstN = 1'b0; initStart = 1'b0; busGrant = 1'b1; writeBusy = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runInit();
    testIntervalAndSameEdge();
    testWriteDrain();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule